// File: doc/BRIEF.md
# Prioritized Transmit Buffer Scheduler

This block manages a small set of transmit message buffers for a frame-based bus controller. It does not store the frames. Each buffer has its own small state machine. Software moves a buffer between its states through a command word. That word selects a group of buffers and applies up to three operations to them: abort, mark ready, and release to empty. A packed priority word gives each buffer a 3-bit rank.

Whenever the transmitter is idle, the scheduler looks at the ready buffers and picks the one with the highest rank. It then offers that buffer's index on a valid/done handshake. The index stays offered until the transmitter reports completion, either success or failure. Completion updates the buffer's state, bumps a frame counter on success, and raises maskable event pulses. A flag reports whether any buffer is free for a new frame.

Top module: `txbuf_sched`

## Requirements
- R1: After reset every buffer is empty, `tx_count` is 0, `tx_valid`, `evt_tx` and `evt_chg` are 0, and `buf_avail` is 1. Every priority resets to 0.
- R2: Buffer i's state is reported in `buf_status[4i+3:4i]` with the codes empty=8, ready=1, sent-OK=4, failed=6 and aborted=7.
- R3: An abort moves a selected ready buffer to aborted and leaves every other state unchanged. It has no effect on the buffer currently offered to the transmitter.
- R4: Set-ready moves a selected buffer from sent-OK, failed, aborted or empty to ready. It leaves a ready buffer unchanged.
- R5: Set-empty moves a selected buffer from sent-OK, failed or aborted to empty. It leaves a ready or empty buffer unchanged.
- R6: Within one accepted command the operations apply in the order abort, then set-ready, then set-empty. Unselected buffers (`cmd_sel` bit 0) are untouched. A completion in the same cycle is applied before the command.
- R7: While `enable` is 0, buffer commands have no effect and no new transmission is offered. A transmission already offered still completes.
- R8: Buffer i's priority is `prio_wdata[4i+2:4i]`, loaded on `prio_we`. The scheduler offers the ready buffer whose priority is strictly above every lower-index candidate and above 0. So a priority-0 buffer is never offered, and ties go to the lowest index.
- R9: A transmission is offered one cycle after an idle, enabled cycle in which a candidate exists and no buffer command is accepted. `tx_valid` then stays high, with `tx_idx` constant, until the cycle in which `tx_done` is sampled high.
- R10: On completion with `tx_err`=0 the buffer becomes sent-OK and `tx_count` increments, wrapping at its width. With `tx_err`=1 the buffer becomes failed and the count is unchanged.
- R11: In the cycle after a completion, `evt_tx` pulses for a successful one unless `evt_mask[0]` is set. `evt_chg` pulses for any completion unless `evt_mask[1]` is set.
- R12: `buf_avail` is 1 exactly when at least one buffer is empty.
- R13: `cmd_valid` with `cmd_clr_count` clears `tx_count` regardless of `enable`, and it takes precedence over a simultaneous increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Controller enabled |
| cmd_valid | input | 1 | Command word presented this cycle |
| cmd_sel | input | NBUF | One select bit per buffer |
| cmd_abort | input | 1 | Abort operation |
| cmd_set_ready | input | 1 | Set-ready operation |
| cmd_set_empty | input | 1 | Set-empty operation |
| cmd_clr_count | input | 1 | Clear the frame counter |
| prio_we | input | 1 | Load the priority word |
| prio_wdata | input | 4*NBUF | Packed priorities, 3 bits per 4-bit field |
| evt_mask | input | 2 | Bit 0 masks evt_tx, bit 1 masks evt_chg |
| tx_valid | output | 1 | A buffer is offered to the transmitter |
| tx_idx | output | IW | Index of the offered buffer |
| tx_done | input | 1 | Transmitter finished the offered buffer |
| tx_err | input | 1 | With tx_done: the transmission failed |
| buf_status | output | 4*NBUF | Packed buffer states |
| buf_avail | output | 1 | At least one buffer is empty |
| tx_count | output | CNTW | Successful frame counter |
| evt_tx | output | 1 | Successful-transmit event pulse |
| evt_chg | output | 1 | Buffer-state-changed event pulse |

## Verification
On every cycle, the assertions check the following:
- The offered index stays stable.
- The offered buffer stays ready while offered.
- A launched buffer had nonzero priority.
- A disabled controller leaves buffer states frozen.
- Event pulses follow only genuine completions.
- The counter increments or clears exactly as commanded.

Other behaviours only show up in the bench's scenarios against its reference model:
- Ordering of the three operations within one write.
- Tie-breaking toward the lower index.
- Never choosing priority 0.
- The one-cycle launch rule around accepted commands.
- The empty-buffer flag.

// File: rtl/txbuf_pkg.sv
package txbuf_pkg;
  typedef enum logic [3:0] {
    ST_READY = 4'h1,
    ST_OK    = 4'h4,
    ST_ERR   = 4'h6,
    ST_ABORT = 4'h7,
    ST_EMPTY = 4'h8
  } buf_state_e;

  localparam int FIELD_W = 4;
  localparam int PRIO_W  = 3;
endpackage

// File: rtl/txbuf_slot.sv
module txbuf_slot
  import txbuf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_hit,
  input  logic       cmd_abort,
  input  logic       cmd_set_ready,
  input  logic       cmd_set_empty,
  input  logic       inflight,
  input  logic       done_hit,
  input  logic       done_err,
  output logic [3:0] state
);
  buf_state_e st_q, base, s1, s2, s3;

  always_comb begin
    // completion first, then the command operations in fixed order
    base = st_q;
    if (done_hit) base = done_err ? ST_ERR : ST_OK;
    s1 = base;
    if (cmd_hit && cmd_abort && base == ST_READY && !(inflight && !done_hit))
      s1 = ST_ABORT;
    s2 = s1;
    if (cmd_hit && cmd_set_ready &&
        (s1 == ST_OK || s1 == ST_ERR || s1 == ST_ABORT || s1 == ST_EMPTY))
      s2 = ST_READY;
    s3 = s2;
    if (cmd_hit && cmd_set_empty &&
        (s2 == ST_OK || s2 == ST_ERR || s2 == ST_ABORT))
      s3 = ST_EMPTY;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= ST_EMPTY;
    else        st_q <= s3;
  end

  assign state = st_q;
endmodule

// File: rtl/txbuf_pick.sv
module txbuf_pick
  import txbuf_pkg::*;
#(
  parameter int NBUF = 4,
  localparam int IW = (NBUF > 1) ? $clog2(NBUF) : 1
) (
  input  logic [FIELD_W*NBUF-1:0] states,
  input  logic [FIELD_W*NBUF-1:0] prios,
  output logic                    found,
  output logic [IW-1:0]           idx
);
  logic [PRIO_W-1:0] best;

  always_comb begin
    best = '0;
    idx  = '0;
    for (int i = 0; i < NBUF; i++) begin
      if (states[FIELD_W*i +: FIELD_W] == ST_READY &&
          prios[FIELD_W*i +: PRIO_W] > best) begin
        best = prios[FIELD_W*i +: PRIO_W];
        idx  = IW'(i);
      end
    end
    found = (best != '0);
  end
endmodule

// File: rtl/txbuf_sched.sv
module txbuf_sched
  import txbuf_pkg::*;
#(
  parameter int NBUF = 4,
  parameter int CNTW = 16,
  localparam int IW = (NBUF > 1) ? $clog2(NBUF) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    enable,
  input  logic                    cmd_valid,
  input  logic [NBUF-1:0]         cmd_sel,
  input  logic                    cmd_abort,
  input  logic                    cmd_set_ready,
  input  logic                    cmd_set_empty,
  input  logic                    cmd_clr_count,
  input  logic                    prio_we,
  input  logic [FIELD_W*NBUF-1:0] prio_wdata,
  input  logic [1:0]              evt_mask,
  output logic                    tx_valid,
  output logic [IW-1:0]           tx_idx,
  input  logic                    tx_done,
  input  logic                    tx_err,
  output logic [FIELD_W*NBUF-1:0] buf_status,
  output logic                    buf_avail,
  output logic [CNTW-1:0]         tx_count,
  output logic                    evt_tx,
  output logic                    evt_chg
);
  logic                    busy_q;
  logic [IW-1:0]           cur_q;
  logic [FIELD_W*NBUF-1:0] prio_q;
  logic                    cmd_acc, done, launch, found;
  logic [IW-1:0]           pick_idx;
  logic [NBUF-1:0]         empty_v;

  assign cmd_acc = cmd_valid && enable;
  assign done    = busy_q && tx_done;
  assign launch  = enable && !busy_q && !cmd_acc && found;

  for (genvar g = 0; g < NBUF; g++) begin : g_slot
    txbuf_slot u_slot (
      .clk          (clk),
      .rst_n        (rst_n),
      .cmd_hit      (cmd_acc && cmd_sel[g]),
      .cmd_abort    (cmd_abort),
      .cmd_set_ready(cmd_set_ready),
      .cmd_set_empty(cmd_set_empty),
      .inflight     (busy_q && cur_q == IW'(g)),
      .done_hit     (done && cur_q == IW'(g)),
      .done_err     (tx_err),
      .state        (buf_status[FIELD_W*g +: FIELD_W])
    );
    assign empty_v[g] = (buf_status[FIELD_W*g +: FIELD_W] == ST_EMPTY);
  end

  txbuf_pick #(.NBUF(NBUF)) u_pick (
    .states(buf_status),
    .prios (prio_q),
    .found (found),
    .idx   (pick_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      cur_q    <= '0;
      prio_q   <= '0;
      tx_count <= '0;
      evt_tx   <= 1'b0;
      evt_chg  <= 1'b0;
    end else begin
      if (done)        busy_q <= 1'b0;
      else if (launch) begin
        busy_q <= 1'b1;
        cur_q  <= pick_idx;
      end
      if (prio_we) prio_q <= prio_wdata;
      if (cmd_valid && cmd_clr_count) tx_count <= '0;
      else if (done && !tx_err)       tx_count <= tx_count + 1'b1;
      evt_tx  <= done && !tx_err && !evt_mask[0];
      evt_chg <= done && !evt_mask[1];
    end
  end

  assign tx_valid  = busy_q;
  assign tx_idx    = cur_q;
  assign buf_avail = |empty_v;
endmodule

// File: rtl/txbuf_sched_chk.sv
module txbuf_sched_chk
  import txbuf_pkg::*;
#(
  parameter int NBUF = 4,
  parameter int CNTW = 16,
  localparam int IW = (NBUF > 1) ? $clog2(NBUF) : 1
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    enable,
  input logic                    cmd_valid,
  input logic                    cmd_clr_count,
  input logic                    tx_valid,
  input logic [IW-1:0]           tx_idx,
  input logic                    tx_done,
  input logic                    tx_err,
  input logic [1:0]              evt_mask,
  input logic [FIELD_W*NBUF-1:0] buf_status,
  input logic [FIELD_W*NBUF-1:0] prio_q,
  input logic [CNTW-1:0]         tx_count,
  input logic                    evt_tx,
  input logic                    evt_chg
);
  logic [FIELD_W*NBUF-1:0] prio_d;
  always_ff @(posedge clk) begin
    if (!rst_n) prio_d <= '0;
    else        prio_d <= prio_q;
  end

  // R9: offer held with stable index until done
  p_hold_offer_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_done |=> tx_valid && $stable(tx_idx));

  // R3: the offered buffer cannot leave ready before completion
  p_offer_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> buf_status[{tx_idx, 2'b00} +: 4] == ST_READY);

  // R8: a launched buffer had nonzero priority at the selection cycle
  p_nonzero_prio_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_valid) |-> prio_d[{tx_idx, 2'b00} +: 3] != 3'd0);

  // R7: frozen states while disabled and no completion
  p_disabled_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !enable && !(tx_valid && tx_done) |=> $stable(buf_status));

  // R10: successful completion counts once
  p_count_inc_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_done && !tx_err && !(cmd_valid && cmd_clr_count)
    |=> tx_count == CNTW'($past(tx_count) + 1'b1));

  // R13: clear wins
  p_count_clear_r13: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_clr_count |=> tx_count == '0);

  // R11: events only follow unmasked completions
  p_evt_tx_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_tx) |-> $past(tx_valid && tx_done && !tx_err && !evt_mask[0]));
  p_evt_chg_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_chg) |-> $past(tx_valid && tx_done && !evt_mask[1]));
endmodule

bind txbuf_sched txbuf_sched_chk #(.NBUF(NBUF), .CNTW(CNTW)) u_chk (.*);

// File: tb/txbuf_sched_bench.sv
module txbuf_sched_bench;
  localparam int NBUF = 4;
  localparam int CNTW = 16;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0, cmd_valid = 1'b0, cmd_abort = 1'b0, cmd_set_ready = 1'b0;
  logic cmd_set_empty = 1'b0, cmd_clr_count = 1'b0, prio_we = 1'b0;
  logic [NBUF-1:0] cmd_sel = '0;
  logic [4*NBUF-1:0] prio_wdata = '0;
  logic [1:0] evt_mask = '0;
  logic tx_done = 1'b0, tx_err = 1'b0;
  logic tx_valid, buf_avail, evt_tx, evt_chg;
  logic [IW-1:0] tx_idx;
  logic [4*NBUF-1:0] buf_status;
  logic [CNTW-1:0] tx_count;

  int checks = 0, errors = 0, done_pct = 0;
  bit finished = 0;

  // reference model state
  int m_st[NBUF], m_prio[NBUF];
  bit m_busy, m_etx, m_echg;
  int m_idx, m_cnt;

  always #2.5 clk = ~clk;

  txbuf_sched #(.NBUF(NBUF), .CNTW(CNTW)) u_txbuf_sched (.*);

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_status();
    int v = 0;
    for (int i = 0; i < NBUF; i++) v |= (m_st[i] & 15) << (4*i);
    return v;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < NBUF; i++) begin m_st[i] = 8; m_prio[i] = 0; end
    m_busy = 0; m_idx = 0; m_cnt = 0; m_etx = 0; m_echg = 0;
  endtask

  task automatic model_step();
    bit acc, done, launch, inflight, dh;
    int best, pick, b;
    acc = cmd_valid && enable;
    done = m_busy && tx_done;
    best = 0; pick = 0;
    for (int i = 0; i < NBUF; i++)
      if (m_st[i] == 1 && m_prio[i] > best) begin best = m_prio[i]; pick = i; end
    launch = enable && !m_busy && !acc && best != 0;
    for (int i = 0; i < NBUF; i++) begin
      inflight = m_busy && m_idx == i;
      dh = done && m_idx == i;
      b = dh ? (tx_err ? 6 : 4) : m_st[i];
      if (acc && cmd_sel[i]) begin
        if (cmd_abort && b == 1 && !(inflight && !dh)) b = 7;
        if (cmd_set_ready && (b == 4 || b == 6 || b == 7 || b == 8)) b = 1;
        if (cmd_set_empty && (b == 4 || b == 6 || b == 7)) b = 8;
      end
      m_st[i] = b;
    end
    if (done) m_busy = 0;
    else if (launch) begin m_busy = 1; m_idx = pick; end
    if (cmd_valid && cmd_clr_count) m_cnt = 0;
    else if (done && !tx_err) m_cnt = (m_cnt + 1) & 16'hffff;
    m_etx = done && !tx_err && !evt_mask[0];
    m_echg = done && !evt_mask[1];
    if (prio_we) for (int i = 0; i < NBUF; i++) m_prio[i] = (prio_wdata >> (4*i)) & 7;
  endtask

  task automatic compare(string tag);
    bit av = 0;
    for (int i = 0; i < NBUF; i++) if (m_st[i] == 8) av = 1;
    check({tag, " status"}, int'(buf_status), exp_status());
    check({tag, " valid R9"}, int'(tx_valid), int'(m_busy));
    if (m_busy) check({tag, " idx R8"}, int'(tx_idx), m_idx);
    check({tag, " count R10"}, int'(tx_count), m_cnt);
    check({tag, " avail R12"}, int'(buf_avail), int'(av));
    check({tag, " evt_tx R11"}, int'(evt_tx), int'(m_etx));
    check({tag, " evt_chg R11"}, int'(evt_chg), int'(m_echg));
  endtask

  // called at a negedge with inputs already driven
  task automatic step(string tag);
    tx_done = tx_valid && (($urandom % 100) < done_pct);
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic cmd(string tag, logic [3:0] sel, bit ab, bit rd, bit em, bit clr);
    cmd_valid = 1; cmd_sel = sel; cmd_abort = ab; cmd_set_ready = rd;
    cmd_set_empty = em; cmd_clr_count = clr;
    step(tag);
    cmd_valid = 0; cmd_sel = '0; cmd_abort = 0; cmd_set_ready = 0;
    cmd_set_empty = 0; cmd_clr_count = 0;
  endtask

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    compare("R1 reset");
    check("R2 reset codes", int'(buf_status), 16'h8888);
    check("R1 avail", int'(buf_avail), 1);
    enable = 1;

    // priority 0 buffer is never offered
    cmd("R4 ready b0", 4'b0001, 0, 1, 0, 0);
    check("R2 ready code", int'(buf_status[3:0]), 1);
    repeat (3) step("R8 prio0 idle");
    check("R8 prio0 never", int'(tx_valid), 0);

    // ties to lowest index
    prio_we = 1; prio_wdata = 16'h2330; step("R8 prio load"); prio_we = 0;
    cmd("R4 ready b1-3", 4'b1110, 0, 1, 0, 0);
    step("R9 launch");
    check("R8 tie lowest", int'(tx_idx), 1);
    check("R9 valid", int'(tx_valid), 1);
    repeat (3) step("R9 hold");

    evt_mask = 2'b00; done_pct = 100; step("R10 done"); done_pct = 0;
    check("R10 count", int'(tx_count), 1);
    check("R10 ok code", int'(buf_status[7:4]), 4);
    check("R11 evt_tx", int'(evt_tx), 1);
    step("R9 relaunch");
    check("R8 next pick", int'(tx_idx), 2);

    enable = 0;
    cmd("R7 disabled", 4'b1111, 1, 0, 1, 0);
    check("R7 unchanged b1", int'(buf_status[7:4]), 4);
    cmd("R13 clear disabled", 4'b0000, 0, 0, 0, 1);
    check("R13 cleared", int'(tx_count), 0);
    enable = 1;

    cmd("R6 order", 4'b1000, 1, 1, 1, 0);
    check("R6 stays ready", int'(buf_status[15:12]), 1);
    cmd("R3 abort", 4'b1000, 1, 0, 0, 0);
    check("R3 aborted", int'(buf_status[15:12]), 7);
    cmd("R3 abort inflight", 4'b0100, 1, 0, 0, 0);
    check("R3 inflight kept", int'(buf_status[11:8]), 1);
    cmd("R5 empty", 4'b1010, 0, 0, 1, 0);
    check("R5 emptied", int'(buf_status[15:12]), 8);
    cmd("R4 fill", 4'b1010, 0, 1, 0, 0);
    check("R12 none empty", int'(buf_avail), 0);
    tx_err = 1; evt_mask = 2'b01; done_pct = 100; step("R10 error"); done_pct = 0;
    check("R10 err code", int'(buf_status[11:8]), 6);
    check("R11 chg", int'(evt_chg), 1);
    tx_err = 0;

    // random phase
    done_pct = 40;
    for (int n = 0; n < 3000; n++) begin
      enable = ($urandom % 10) != 0;
      evt_mask = 2'($urandom);
      tx_err = ($urandom % 8) == 0;
      prio_we = ($urandom % 10) == 0;
      prio_wdata = 16'($urandom);
      cmd_valid = ($urandom % 3) == 0;
      cmd_sel = 4'($urandom);
      cmd_abort = 1'($urandom); cmd_set_ready = 1'($urandom);
      cmd_set_empty = 1'($urandom); cmd_clr_count = ($urandom % 20) == 0;
      step("R6 random");
    end
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule